// File: doc/BRIEF.md
# PWM Fault Protection Controller

This block sits between a complementary multi-pair PWM generator and the output pads. Each pair has a high-side and a low-side output, so the build has twice as many outputs as pairs. In normal operation each raw channel bit is turned into a pad level according to the active-level setting for its side. The result passes through one register. The block also drives a per-output enable that hands a pad to the PWM path or leaves it to general I/O.

Two active-low fault pins, A and B, can force every enabled output to its inactive level. Because the pins are active-low, many open-drain sources can share one pin. Each pin has its own enable, its own mode and its own status flag. In latched mode a fault holds the outputs off until the pin has returned high and software has cleared the flag. In cycle-by-cycle mode the outputs come back by themselves once the pin is high. In both modes outputs resume only at the edge that samples the period-start strobe.

A small register port sets up the two fault inputs and the output-enable field, and reads back their state. A boot strap, sampled during reset, chooses whether the outputs come up enabled or released to general I/O.

Top module: `pwm_fault_guard`

## Requirements
- R1: During reset the output-enable field (address 1, bits [2:0]) loads 0 when `boot_pwm_on` is 0, and NUM_PAIRS+1 when it is 1 (5 for the default 8-output build). With the field at 0 every `pwm_oe` and `pwm_pin` bit is 0. With the boot value, all outputs are enabled.
- R2: Enable field value v below 4 disables every output. A value of 4 or more enables pairs 0 to min(v-1, NUM_PAIRS)-1. Output 2i is the high side of pair i and output 2i+1 is the low side. A write reaches `pwm_oe` two cycles after it is sampled.
- R3: With no fault override, an enabled output drives its side's active level when its raw bit is 1 and the opposite level when the bit is 0. The active level is `pol_high` for the high side and `pol_low` for the low side. Outputs follow the inputs one cycle later. Disabled outputs drive 0.
- R4: Fault pins are active-low and pass through a two-flop synchronizer. An enabled fault pin falling forces all enabled outputs inactive on the third clock edge after the fall, with no wait for the period strobe.
- R5: A fault input whose enable bit is 0 has no effect. Outputs keep following the raw bits and its status bit stays 0.
- R6: Address 0 reads {B status, A status, B mode, B enable, A mode, A enable} in bits [5:0]. A status reads 1 after its enabled fault is seen.
- R7: In latched mode (mode bit 0), outputs stay inactive through period strobes until the pin is high and software has written 1 to that fault's status bit (bit 4 for A, bit 5 for B) at address 0.
- R8: A status-clear write that arrives while the synchronized fault is still low is ignored, and the status stays 1.
- R9: After a latched fault is cleared, outputs stay inactive until the next period strobe. They resume at the clock edge that samples that strobe.
- R10: In cycle-by-cycle mode (mode bit 1), outputs stay inactive while the pin is low and until the first strobe after it goes high. At that edge outputs resume and the status bit clears by itself.
- R11: The two fault inputs are tracked separately. Outputs are released only when neither tracker holds them.
- R12: Inactive levels follow the polarity inputs while the override is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_pwm_on | input | 1 | Reset strap: outputs come up enabled when 1 |
| pol_high | input | 1 | Active pad level for high-side outputs |
| pol_low | input | 1 | Active pad level for low-side outputs |
| pwm_raw | input | 2*NUM_PAIRS | Raw channel states from the generator, 1 = on |
| period_start | input | 1 | One-cycle strobe at each PWM period start |
| fault_a_n | input | 1 | Fault pin A, active low |
| fault_b_n | input | 1 | Fault pin B, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 fault control/status, 1 output enable |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Registered read data for `reg_addr` |
| pwm_pin | output | 2*NUM_PAIRS | Pad drive levels |
| pwm_oe | output | 2*NUM_PAIRS | Pad enables, 1 = PWM owns the pad |

## Verification
The hardest case to reach is a latched release. It needs the pin back high, a clear that lands only after the synchronizer has seen the pin high, and then a period strobe. The stimulus first issues a clear while the pin is still low and checks that it is ignored. It then raises the pin and sends a strobe before clearing, and checks that the outputs stay off. Finally it clears, then checks the cycle before and the cycle at which the strobe is sampled. The two-fault case overlaps the pins so that one tracker is ready to release while the other is still active.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int REG_W   = 6;
  localparam int OUTEN_W = 3;

  localparam logic ADDR_FAULT = 1'b0;
  localparam logic ADDR_OUTEN = 1'b1;

  typedef enum logic {
    MODE_LATCH = 1'b0,
    MODE_CYCLE = 1'b1
  } flt_mode_e;

  typedef struct packed {
    flt_mode_e mode;
    logic      en;
  } flt_cfg_t;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fault_channel.sv
module fault_channel
  import pwm_fault_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     flt_act,
  input  flt_cfg_t cfg,
  input  logic     clr_req,
  input  logic     period_start,
  output logic     stat,
  output logic     hold,
  output logic     block
);
  logic active;
  logic release_now;

  assign active      = cfg.en & flt_act;
  assign release_now = period_start & ((cfg.mode == MODE_CYCLE) | ~stat);
  assign block       = active | (hold & ~release_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= 1'b0;
      hold <= 1'b0;
    end else if (active) begin
      stat <= 1'b1;
      hold <= 1'b1;
    end else begin
      if (!cfg.en || release_now) hold <= 1'b0;
      if (clr_req) stat <= 1'b0;
      else if (cfg.mode == MODE_CYCLE && hold && release_now) stat <= 1'b0;
    end
  end

  assert_set_on_fault_R6: assert property (@(posedge clk) disable iff (rst)
    active |=> (stat && hold));

  assert_clear_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (active && clr_req) |=> stat);

  assert_latched_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_LATCH && stat && !clr_req) |=> stat);

  assert_release_on_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |-> ($past(period_start) || !$past(cfg.en)));

  assert_disabled_no_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg.en |=> !hold);
endmodule

// File: rtl/fault_regs.sv
module fault_regs
  import pwm_fault_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               boot_pwm_on,
  input  logic               wr,
  input  logic               addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               stat_a,
  input  logic               stat_b,
  output flt_cfg_t           cfg_a,
  output flt_cfg_t           cfg_b,
  output logic               clr_a,
  output logic               clr_b,
  output logic [OUTEN_W-1:0] outen,
  output logic [REG_W-1:0]   rdata
);
  localparam logic [OUTEN_W-1:0] BOOT_OUTEN = OUTEN_W'(NUM_PAIRS + 1);

  logic wr_fault;
  logic wr_outen;

  assign wr_fault = wr && (addr == ADDR_FAULT);
  assign wr_outen = wr && (addr == ADDR_OUTEN);
  assign clr_a    = wr_fault && wdata[4];
  assign clr_b    = wr_fault && wdata[5];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a <= '0;
      cfg_b <= '0;
      outen <= boot_pwm_on ? BOOT_OUTEN : '0;
    end else begin
      if (wr_fault) begin
        cfg_a.en   <= wdata[0];
        cfg_a.mode <= flt_mode_e'(wdata[1]);
        cfg_b.en   <= wdata[2];
        cfg_b.mode <= flt_mode_e'(wdata[3]);
      end
      if (wr_outen) outen <= wdata[OUTEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (addr == ADDR_FAULT)
      rdata <= {stat_b, stat_a, cfg_b.mode, cfg_b.en, cfg_a.mode, cfg_a.en};
    else
      rdata <= {{(REG_W-OUTEN_W){1'b0}}, outen};
  end

  assert_outen_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_outen |=> $stable(outen));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_fault_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  localparam int NUM_OUT  = 2 * NUM_PAIRS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OUT-1:0] raw,
  input  logic               blocked,
  input  logic               pol_high,
  input  logic               pol_low,
  input  logic [OUTEN_W-1:0] outen,
  output logic [NUM_OUT-1:0] pin,
  output logic [NUM_OUT-1:0] oe
);
  int pairs_on;
  logic [NUM_OUT-1:0] idle_lvl;

  always_comb begin
    if (outen[OUTEN_W-1]) pairs_on = int'(outen) - 1;
    else                  pairs_on = 0;
    if (pairs_on > NUM_PAIRS) pairs_on = NUM_PAIRS;
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    localparam int PAIR = i / 2;
    localparam bit LOW  = (i % 2) == 1;
    logic act_lvl;
    logic lane_en;
    logic lane_on;

    assign act_lvl     = LOW ? pol_low : pol_high;
    assign idle_lvl[i] = ~act_lvl;
    assign lane_en     = PAIR < pairs_on;
    assign lane_on     = raw[i] & ~blocked;

    always_ff @(posedge clk) begin
      if (rst) begin
        pin[i] <= 1'b0;
        oe[i]  <= 1'b0;
      end else begin
        oe[i]  <= lane_en;
        pin[i] <= lane_en & (lane_on ? act_lvl : ~act_lvl);
      end
    end
  end

  assert_block_idle_R4: assert property (@(posedge clk) disable iff (rst)
    blocked |=> (((pin ^ $past(idle_lvl)) & oe) == '0));
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pwm_fault_pkg::*;
#(
  parameter int NUM_PAIRS   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_OUT    = 2 * NUM_PAIRS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               boot_pwm_on,
  input  logic               pol_high,
  input  logic               pol_low,
  input  logic [NUM_OUT-1:0] pwm_raw,
  input  logic               period_start,
  input  logic               fault_a_n,
  input  logic               fault_b_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [NUM_OUT-1:0] pwm_pin,
  output logic [NUM_OUT-1:0] pwm_oe
);
  logic [1:0]         pin_n;
  logic [1:0]         sync_n;
  logic [1:0]         stat;
  logic [1:0]         hold;
  logic [1:0]         block;
  logic [1:0]         clr;
  flt_cfg_t           cfg [2];
  logic [OUTEN_W-1:0] outen;
  logic               blocked;

  assign pin_n = {fault_b_n, fault_a_n};

  for (genvar f = 0; f < 2; f++) begin : g_fault
    fault_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
      .clk (clk),
      .rst (rst),
      .d   (pin_n[f]),
      .q   (sync_n[f])
    );

    fault_channel chan_i (
      .clk          (clk),
      .rst          (rst),
      .flt_act      (~sync_n[f]),
      .cfg          (cfg[f]),
      .clr_req      (clr[f]),
      .period_start (period_start),
      .stat         (stat[f]),
      .hold         (hold[f]),
      .block        (block[f])
    );
  end

  assign blocked = |block;

  fault_regs #(.NUM_PAIRS(NUM_PAIRS)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .boot_pwm_on (boot_pwm_on),
    .wr          (reg_wr),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .stat_a      (stat[0]),
    .stat_b      (stat[1]),
    .cfg_a       (cfg[0]),
    .cfg_b       (cfg[1]),
    .clr_a       (clr[0]),
    .clr_b       (clr[1]),
    .outen       (outen),
    .rdata       (reg_rdata)
  );

  pwm_out_stage #(.NUM_PAIRS(NUM_PAIRS)) out_i (
    .clk      (clk),
    .rst      (rst),
    .raw      (pwm_raw),
    .blocked  (blocked),
    .pol_high (pol_high),
    .pol_low  (pol_low),
    .outen    (outen),
    .pin      (pwm_pin),
    .oe       (pwm_oe)
  );

  assert_release_needs_both_R11: assert property (@(posedge clk) disable iff (rst)
    (hold[0] && !period_start) |-> blocked);
endmodule

// File: tb/pwm_fault_guard_tb_top.sv
module pwm_fault_guard_tb_top;
  localparam int NP = 4;
  localparam int NO = 2 * NP;
  localparam time CLK_PERIOD = 20ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          boot_pwm_on = 1'b0;
  logic          pol_high = 1'b1;
  logic          pol_low = 1'b0;
  logic [NO-1:0] pwm_raw = 8'hA5;
  logic          period_start = 1'b0;
  logic          fault_a_n = 1'b1;
  logic          fault_b_n = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_addr = 1'b0;
  logic [5:0]    reg_wdata = '0;
  logic [5:0]    reg_rdata;
  logic [NO-1:0] pwm_pin;
  logic [NO-1:0] pwm_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_fault_guard #(.NUM_PAIRS(NP)) dut_i (
    .clk (clk), .rst (rst), .boot_pwm_on (boot_pwm_on),
    .pol_high (pol_high), .pol_low (pol_low), .pwm_raw (pwm_raw),
    .period_start (period_start), .fault_a_n (fault_a_n), .fault_b_n (fault_b_n),
    .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .pwm_pin (pwm_pin), .pwm_oe (pwm_oe)
  );

  typedef struct {
    int        cyc;
    bit        is_reg;
    logic [7:0] pins;
    logic [7:0] oe;
    logic [5:0] rd;
    logic [5:0] mask;
    string     tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  int   npairs = 0;
  bit   done = 1'b0;

  function automatic logic [NO-1:0] model_pins(logic [NO-1:0] r, bit blk, int np, bit ph, bit pl);
    logic [NO-1:0] v;
    for (int i = 0; i < NO; i++) begin
      bit pol;
      pol = (i % 2 == 1) ? pl : ph;
      if (i / 2 < np) v[i] = (r[i] && !blk) ? pol : !pol;
      else            v[i] = 1'b0;
    end
    return v;
  endfunction

  function automatic logic [NO-1:0] model_oe(int np);
    logic [NO-1:0] v;
    for (int i = 0; i < NO; i++) v[i] = (i / 2 < np);
    return v;
  endfunction

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic exp_out(int d, bit blk, string tag);
    exp_t e;
    e.cyc = cyc + d; e.is_reg = 1'b0;
    e.pins = model_pins(pwm_raw, blk, npairs, pol_high, pol_low);
    e.oe = model_oe(npairs); e.rd = '0; e.mask = '0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic rd(logic a, logic [5:0] v, logic [5:0] m, string tag);
    exp_t e;
    reg_addr = a;
    e.cyc = cyc + 1; e.is_reg = 1'b1; e.pins = '0; e.oe = '0;
    e.rd = v; e.mask = m; e.tag = tag;
    exp_q.push_back(e);
    tick(1);
  endtask

  task automatic wr(logic a, logic [5:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic strobe();
    period_start = 1'b1;
    tick(1);
    period_start = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // monitor: pops scoreboard items due this cycle and compares
  always @(negedge clk) begin
    cyc++;
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].cyc == cyc) begin
        n_checks++;
        if (exp_q[i].is_reg) begin
          if (((reg_rdata ^ exp_q[i].rd) & exp_q[i].mask) != '0) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected=%h mask=%h", exp_q[i].tag,
                     reg_rdata, exp_q[i].rd, exp_q[i].mask);
          end
        end else if (pwm_pin !== exp_q[i].pins || pwm_oe !== exp_q[i].oe) begin
          n_fail++;
          $display("FAIL %s: pin=%h oe=%h expected pin=%h oe=%h", exp_q[i].tag,
                   pwm_pin, pwm_oe, exp_q[i].pins, exp_q[i].oe);
        end
        exp_q.delete(i);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    summary();
  end

  initial begin
    // R1: reset with outputs released to general I/O
    tick(3);
    rst = 1'b0; npairs = 0;
    exp_out(2, 0, "R1 boot off");
    tick(2);
    rd(1'b1, 6'h00, 6'h07, "R1 field zero");

    // R1: reset with outputs enabled
    rst = 1'b1; boot_pwm_on = 1'b1;
    tick(3);
    rst = 1'b0; npairs = NP;
    exp_out(2, 0, "R1 boot on");
    tick(2);
    rd(1'b1, 6'h05, 6'h07, "R1 field boot value");

    // R3: pass-through under two patterns and swapped polarities
    pwm_raw = 8'h3C; exp_out(1, 0, "R3 pattern");
    tick(2);
    pol_high = 1'b0; pol_low = 1'b1; exp_out(1, 0, "R3 polarity");
    tick(2);
    pol_high = 1'b1; pol_low = 1'b0;
    tick(2);

    // R5: disabled faults have no effect
    fault_a_n = 1'b0; fault_b_n = 1'b0;
    tick(5);
    exp_out(1, 0, "R5 outputs");
    rd(1'b0, 6'h00, 6'h30, "R5 status");
    fault_a_n = 1'b1; fault_b_n = 1'b1;
    tick(4);

    // R2: enable field decoding
    wr(1'b1, 6'h04); npairs = 3; exp_out(1, 0, "R2 three pairs");
    tick(1);
    wr(1'b1, 6'h02); npairs = 0; exp_out(1, 0, "R2 below four");
    tick(1);
    wr(1'b1, 6'h07); npairs = NP; exp_out(1, 0, "R2 clamp");
    tick(1);
    rd(1'b1, 6'h07, 6'h07, "R2 readback");

    // R4/R6/R7/R8/R9: fault A latched, mid-period
    pwm_raw = 8'hA5;
    wr(1'b0, 6'h01);
    rd(1'b0, 6'h01, 6'h3F, "R6 control");
    fault_a_n = 1'b0;
    exp_out(2, 0, "R4 before sync");
    exp_out(3, 1, "R4 override");
    tick(4);
    rd(1'b0, 6'h11, 6'h3F, "R6 status A");
    wr(1'b0, 6'h11);
    tick(1);
    rd(1'b0, 6'h11, 6'h3F, "R8 clear while low");
    fault_a_n = 1'b1;
    tick(4);
    exp_out(1, 1, "R7 strobe before clear");
    strobe();
    rd(1'b0, 6'h11, 6'h3F, "R7 status held");
    wr(1'b0, 6'h11);
    tick(2);
    exp_out(1, 1, "R9 no strobe yet");
    tick(3);
    rd(1'b0, 6'h01, 6'h3F, "R7 status cleared");
    exp_out(1, 1, "R9 cycle before strobe");
    exp_out(2, 0, "R9 release at strobe");
    tick(1);
    strobe();
    pwm_raw = 8'h5A; exp_out(1, 0, "R3 after release");
    tick(2);

    // R10: fault B cycle-by-cycle
    wr(1'b0, 6'h0C);
    rd(1'b0, 6'h0C, 6'h3F, "R6 control B");
    fault_b_n = 1'b0;
    exp_out(3, 1, "R10 override");
    tick(3);
    exp_out(1, 1, "R10 strobe while low");
    strobe();
    tick(2);
    rd(1'b0, 6'h2C, 6'h3F, "R10 status set");
    fault_b_n = 1'b1;
    tick(5);
    exp_out(1, 1, "R10 high awaits strobe");
    rd(1'b0, 6'h2C, 6'h3F, "R10 status before release");
    exp_out(1, 1, "R10 cycle before strobe");
    exp_out(2, 0, "R10 release at strobe");
    tick(1);
    strobe();
    tick(1);
    rd(1'b0, 6'h0C, 6'h3F, "R10 auto clear");

    // R11/R12: both faults, overlapping
    wr(1'b0, 6'h0F);
    fault_a_n = 1'b0;
    tick(2);
    fault_b_n = 1'b0;
    tick(4);
    exp_out(1, 1, "R11 both active");
    fault_a_n = 1'b1;
    tick(5);
    exp_out(1, 1, "R11 B still low");
    strobe();
    tick(1);
    pol_low = 1'b1; exp_out(1, 1, "R12 idle follows polarity");
    tick(2);
    pol_low = 1'b0;
    tick(1);
    fault_b_n = 1'b1;
    tick(5);
    exp_out(1, 1, "R11 before strobe");
    exp_out(2, 0, "R11 release");
    tick(1);
    strobe();
    tick(2);
    rd(1'b0, 6'h0F, 6'h3F, "R11 both cleared");

    tick(5);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: pending=%0d expected=0", exp_q.size());
    end
    summary();
  end
endmodule